// File: doc/BRIEF.md
# Delegated Interrupt Priority Selector

This block decides which local interrupt a hart should take next. It holds the hart's pending-interrupt register, qualifies each pending bit with the per-bit enable vector, and then applies a global gate to each bit. Bits routed to the supervisor level by the delegation mask use the supervisor gate. All other bits use the machine gate. Both gates depend on the current privilege level. The lowest-numbered bit that survives wins. Its index is reported together with a valid flag.

The pending register has two write sources. Hardware sources can set bits in any cycle. Software can perform a masked write that replaces only the selected bits. During that write cycle the previous register contents are presented on a read-back port. A registered request line reports after every clock edge whether any bit is pending. Selection is combinational from the registered pending value and the live control inputs.

Top module: `irq_select_top`

## Requirements
- R1: An interrupt is a candidate only when its bit is set in both the pending register and the `irq_enable` vector. A bit that is pending but not enabled never wins.
- R2: Privilege is a 2-bit code: user=0, supervisor=1, code 2 sits between them, machine=3. The machine gate is open when privilege is below 3. At privilege 3 it is open only while `m_gie` is 1.
- R3: The supervisor gate is open when privilege is below 1 (user). At privilege 1 it is open only while `s_gie` is 1. At privileges 2 and 3 it is closed.
- R4: A candidate whose `deleg_mask` bit is 0 passes only through the machine gate. A candidate whose `deleg_mask` bit is 1 passes only through the supervisor gate.
- R5: When any bit survives gating, `take_valid` is 1 and `take_idx` is the position of the lowest surviving bit. Otherwise `take_valid` is 0 and `take_idx` is 0.
- R6: When `upd_en` is 1 at a rising edge, the pending register becomes (old AND NOT `upd_mask`) OR (`upd_value` AND `upd_mask`) in that one clock.
- R7: While `upd_en` is 1, `upd_old` presents the pending value as it was before the write.
- R8: After every rising edge, `irq_req` is 1 exactly when the new pending value is nonzero.
- R9: On bits selected by `upd_mask`, a masked write overrides a `hw_set` in the same cycle. On bits not selected by the mask, `hw_set` still sets the bit. With no write, `hw_set` bits are ORed in and no bit is cleared.
- R10: While `rst_n` is 0 at a rising edge, the pending register and `irq_req` clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_set | input | 32 | Hardware pending-set strobes |
| upd_en | input | 1 | Masked software write of the pending register |
| upd_mask | input | 32 | Bits replaced by the write |
| upd_value | input | 32 | New values for the masked bits |
| upd_old | output | 32 | Pending value before the write |
| pend | output | 32 | Current pending register |
| irq_req | output | 1 | Registered "any pending" request line |
| irq_enable | input | 32 | Per-interrupt enable vector |
| deleg_mask | input | 32 | 1 = bit handled at supervisor level |
| priv | input | 2 | Current privilege code |
| m_gie | input | 1 | Machine global interrupt enable |
| s_gie | input | 1 | Supervisor global interrupt enable |
| take_valid | output | 1 | An interrupt is selected |
| take_idx | output | 5 | Index of the selected interrupt |

## Verification
A software masked write and a hardware set can land in the same cycle. The bench drives the write and `hw_set` together. Some set bits lie inside the write mask and some lie outside it. The expected register is computed from R9: masked bits follow `upd_value`, and the other bits take the OR. The new pending value, `irq_req` and the selection are all compared after that edge. The read-back of the old value is compared in the same cycle as the write.

// File: rtl/irq_sel_pkg.sv
// Package: shared privilege codes and the default interrupt count.
package irq_sel_pkg;
    localparam int unsigned NIRQ_DEFAULT = 32;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;
endpackage

// File: rtl/irq_pend_reg.sv
// Pending-interrupt register.
// Bits are set by hardware strobes. A masked software write overrides
// hardware sets on the masked bits. The pre-write value is presented as
// read-back, and a registered request line tracks "any bit pending".
// Assumes a synchronous active-low reset.
module irq_pend_reg #(
    parameter int unsigned NIRQ = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] hw_set,
    input  logic            upd_en,
    input  logic [NIRQ-1:0] upd_mask,
    input  logic [NIRQ-1:0] upd_value,
    output logic [NIRQ-1:0] upd_old,
    output logic [NIRQ-1:0] pend_q,
    output logic            irq_req
);
    logic [NIRQ-1:0] pend_d;

    // Next pending value: a masked write wins over a same-cycle set.
    always_comb begin
        pend_d = pend_q | hw_set;
        if (upd_en) begin
            pend_d = (pend_d & ~upd_mask) | (upd_value & upd_mask);
        end
    end

    // Register the pending bits and the request line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            irq_req <= 1'b0;
        end else begin
            pend_q  <= pend_d;
            irq_req <= (pend_d != '0);
        end
    end

    // Read-back of the value before the write.
    assign upd_old = pend_q;

    a_r9_mask_wins: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (((pend_q ^ $past(upd_value)) & $past(upd_mask)) == '0));
    a_r9_no_spurious_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
    a_r8_req_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_req == (pend_q != '0)));
endmodule

// File: rtl/irq_gate.sv
// Global gating of candidate interrupts.
// Non-delegated bits pass through the machine gate and delegated bits pass
// through the supervisor gate. Both gates are derived from the privilege code.
// Purely combinational.
module irq_gate
    import irq_sel_pkg::*;
#(
    parameter int unsigned NIRQ = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] cand,
    input  logic [NIRQ-1:0] deleg,
    input  logic [1:0]      priv,
    input  logic            m_gie,
    input  logic            s_gie,
    output logic [NIRQ-1:0] gated
);
    logic m_open;
    logic s_open;

    // Gate open conditions from privilege and the global enable bits.
    always_comb begin
        m_open = (priv < PRIV_MACH)  || ((priv == PRIV_MACH)  && m_gie);
        s_open = (priv < PRIV_SUPER) || ((priv == PRIV_SUPER) && s_gie);
    end

    // Route each bit through its level's gate.
    always_comb begin
        gated = (cand & ~deleg & {NIRQ{m_open}}) | (cand & deleg & {NIRQ{s_open}});
    end

    a_r1_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (gated & ~cand) == '0);
    a_r2_mach_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (priv == PRIV_MACH && !m_gie) |-> ((gated & ~deleg) == '0));
    a_r3_super_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (priv > PRIV_SUPER) |-> ((gated & deleg) == '0));
endmodule

// File: rtl/irq_pick.sv
// Lowest-index selector.
// A prefix-OR chain isolates the lowest set bit, which is then encoded as an
// index. Reports valid=0 and index 0 for an empty vector.
module irq_pick #(
    parameter int unsigned NIRQ = 32,
    localparam int unsigned IW  = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] req,
    output logic            valid,
    output logic [IW-1:0]   idx
);
    logic [NIRQ-1:0] seen;
    logic [NIRQ-1:0] first;

    // Prefix OR: seen[i] is set when any bit at or below i is set.
    assign seen[0]  = req[0];
    assign first[0] = req[0];
    for (genvar i = 1; i < NIRQ; i++) begin : g_chain
        assign seen[i]  = seen[i-1] | req[i];
        assign first[i] = req[i] & ~seen[i-1];
    end

    // Encode the isolated one-hot bit as an index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < NIRQ; i++) begin
            if (first[i]) idx = idx | IW'(i);
        end
    end

    assign valid = seen[NIRQ-1];

    a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(first) && (valid == (first != '0)));
    a_r5_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (req[idx] && ((req & ((NIRQ'(1) << idx) - NIRQ'(1))) == '0)));
    a_r5_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (req == '0 && idx == '0));
endmodule

// File: rtl/irq_select_top.sv
// Top level of the delegated interrupt priority selector.
// Chains the pending register, the per-bit enable, the delegation-aware
// global gating and the lowest-index picker. Selection is combinational
// from the registered pending value.
module irq_select_top
    import irq_sel_pkg::*;
#(
    parameter int unsigned NIRQ = NIRQ_DEFAULT,
    localparam int unsigned IW  = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] hw_set,
    input  logic            upd_en,
    input  logic [NIRQ-1:0] upd_mask,
    input  logic [NIRQ-1:0] upd_value,
    output logic [NIRQ-1:0] upd_old,
    output logic [NIRQ-1:0] pend,
    output logic            irq_req,
    input  logic [NIRQ-1:0] irq_enable,
    input  logic [NIRQ-1:0] deleg_mask,
    input  logic [1:0]      priv,
    input  logic            m_gie,
    input  logic            s_gie,
    output logic            take_valid,
    output logic [IW-1:0]   take_idx
);
    logic [NIRQ-1:0] cand;
    logic [NIRQ-1:0] gated;

    irq_pend_reg #(.NIRQ(NIRQ)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_set    (hw_set),
        .upd_en    (upd_en),
        .upd_mask  (upd_mask),
        .upd_value (upd_value),
        .upd_old   (upd_old),
        .pend_q    (pend),
        .irq_req   (irq_req)
    );

    // Candidates: pending and individually enabled.
    assign cand = pend & irq_enable;

    irq_gate #(.NIRQ(NIRQ)) u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .cand  (cand),
        .deleg (deleg_mask),
        .priv  (priv),
        .m_gie (m_gie),
        .s_gie (s_gie),
        .gated (gated)
    );

    irq_pick #(.NIRQ(NIRQ)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (gated),
        .valid (take_valid),
        .idx   (take_idx)
    );
endmodule

// File: tb/sim_irq_select_top.sv
// Scoreboard bench: the driver pushes expected results, the monitor compares.
module sim_irq_select_top;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] pend;
        logic        req;
        logic        valid;
        logic [4:0]  idx;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] hw_set = '0, upd_mask = '0, upd_value = '0;
    logic [31:0] irq_enable = '0, deleg_mask = '0;
    logic        upd_en = 1'b0, m_gie = 1'b0, s_gie = 1'b0;
    logic [1:0]  priv = 2'd0;
    logic [31:0] upd_old, pend;
    logic        irq_req, take_valid;
    logic [4:0]  take_idx;

    int checks = 0;
    int fails  = 0;
    exp_t q[$];
    logic [31:0] model_pend = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_select_top u0 (
        .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .upd_en(upd_en),
        .upd_mask(upd_mask), .upd_value(upd_value), .upd_old(upd_old),
        .pend(pend), .irq_req(irq_req), .irq_enable(irq_enable),
        .deleg_mask(deleg_mask), .priv(priv), .m_gie(m_gie), .s_gie(s_gie),
        .take_valid(take_valid), .take_idx(take_idx)
    );

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus plus its expected outcome.
    task automatic step(input logic [31:0] hs, input logic ue, input logic [31:0] um,
                        input logic [31:0] uv, input logic [31:0] en, input logic [31:0] dl,
                        input logic [1:0] pv, input logic mg, input logic sg, input string tag);
        exp_t e;
        logic [31:0] surv;
        logic mo, so;
        @(negedge clk);
        hw_set = hs; upd_en = ue; upd_mask = um; upd_value = uv;
        irq_enable = en; deleg_mask = dl; priv = pv; m_gie = mg; s_gie = sg;
        #1;
        if (ue) check(upd_old == model_pend, {tag, " R7 old value"}, upd_old, model_pend);
        model_pend = model_pend | hs;
        if (ue) model_pend = (model_pend & ~um) | (uv & um);
        mo = (pv != 2'd3) || mg;
        so = (pv == 2'd0) || (pv == 2'd1 && sg);
        surv = (model_pend & en & ~dl & {32{mo}}) | (model_pend & en & dl & {32{so}});
        e.pend = model_pend; e.req = (model_pend != 0); e.tag = tag;
        e.valid = (surv != 0); e.idx = '0;
        for (int i = 31; i >= 0; i--) if (surv[i]) e.idx = 5'(i);
        @(posedge clk);
        q.push_back(e);
    endtask

    // Monitor: compare outputs a quarter period after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(pend == e.pend, {e.tag, " R6 R9 pending"}, pend, e.pend);
                check(irq_req == e.req, {e.tag, " R8 request"}, 32'(irq_req), 32'(e.req));
                check(take_valid == e.valid, {e.tag, " R5 valid"}, 32'(take_valid), 32'(e.valid));
                check(take_idx == e.idx, {e.tag, " R5 index"}, 32'(take_idx), 32'(e.idx));
            end
        end
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 5000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        hw_set = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #1;
        check(pend == 0, "R10 reset pending", pend, 0);
        check(irq_req == 0, "R10 reset request", 32'(irq_req), 0);
        @(negedge clk); hw_set = '0; rst_n = 1'b1;
        // R1 R2 R5: user mode, nothing delegated
        step(32'h88, 0, 0, 0, 32'hFFFF_FFFF, 0, 2'd0, 0, 0, "user");
        step(0, 0, 0, 0, 32'hFFFF_FFF7, 0, 2'd0, 0, 0, "R1 enable mask");
        step(0, 0, 0, 0, 32'hFFFF_FFFF, 0, 2'd3, 0, 0, "R2 mach closed");
        step(0, 0, 0, 0, 32'hFFFF_FFFF, 0, 2'd3, 1, 0, "R2 mach open");
        step(0, 0, 0, 0, 32'hFFFF_FFFF, 0, 2'd2, 0, 0, "R2 code2");
        // R3 R4: bit3 delegated
        step(0, 0, 0, 0, 32'hFFFF_FFFF, 32'h8, 2'd1, 0, 0, "R4 super closed");
        step(0, 0, 0, 0, 32'hFFFF_FFFF, 32'h8, 2'd1, 0, 1, "R3 super open");
        step(0, 0, 0, 0, 32'hFFFF_FFFF, 32'h8, 2'd3, 1, 1, "R4 deleg in mach");
        step(0, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd0, 0, 0, "R3 user below");
        step(0, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd3, 1, 1, "R3 all deleg mach");
        // R6 R7: masked write
        step(0, 1, 32'hF0, 32'h10, 32'hFFFF_FFFF, 0, 2'd0, 0, 0, "R6 masked write");
        // R9: write and hardware set in the same cycle
        step(32'h110, 1, 32'h10, 0, 32'hFFFF_FFFF, 0, 2'd0, 0, 0, "R9 collision");
        // R8: clear everything
        step(0, 1, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, 0, 2'd0, 0, 0, "R8 clear");
        step(0, 1, 32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 2'd0, 0, 0, "R5 top bit");
        step(32'h1, 0, 0, 0, 32'hFFFF_FFFF, 0, 2'd0, 0, 0, "R5 bit zero");
        step(0, 0, 0, 0, 32'h0, 0, 2'd0, 0, 0, "R1 none enabled");
        @(negedge clk); upd_en = 1'b0; hw_set = '0;
        @(posedge clk); #(CLK_PERIOD/2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule